// File: doc/BRIEF.md
# SD card block-read register front-end

This block is the register face of an SD card host, placed on an AHB-Lite slave port with a 64-bit data path. Software first waits for the card-side logic to report that initialization has finished. It then loads a 64-bit block address, writes the read command and polls a busy flag. When the flag drops, it drains one 512-byte block through a single mailbox address, receiving one 64-bit word per load.

The card signalling itself sits outside this block. A backend handshake stands in for it. The front-end raises a one-cycle request that carries the block address, and then it accepts 64 words, one on each cycle in which a valid strobe is high. These words fill an internal 64-entry buffer. The mailbox hands the buffer out in order through a pointer that stops at the last word. A card clock divider register is also held here, and its value is driven out to the clock generator.

Top module: `sd_blockread_regs`

## Requirements
- R1: After reset the divider and block address registers are 0, busy is 0, `blk_req` is 0, `hreadyout` is 1 and `hresp` is 0.
- R2: Writing byte offset 0x00 stores the low 8 bits of `hwdata`. These bits read back at 0x00 in `hrdata[7:0]` and drive `clk_div` from the cycle after the write data phase.
- R3: Reading byte offset 0x04 returns `init_done` in bit 0 and busy in bit 1, with every other bit 0. Writes to 0x04 change nothing.
- R4: Every transfer completes with zero wait states: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R5: Byte offset 0x10 is a 64-bit read/write block address register. While `blk_req` is high, `blk_addr` carries its value.
- R6: A write of exactly 4 to byte offset 0x08, made while `init_done` is 1 and busy is 0, sets busy and raises `blk_req` for exactly one cycle. That cycle is the one right after the write data phase. Any other value written there starts nothing.
- R7: From the cycle after the request, each cycle with `blk_valid` high stores `blk_data` as the next buffer word. Strobes seen while idle or during the request cycle are ignored. Busy clears in the cycle after the 64th word is accepted.
- R8: Each load from byte offset 0x18 returns the next buffer word. Every accepted read command restarts the sequence at word 0. Loads past word 63 keep returning word 63.
- R9: A command write is ignored, with no request and no busy change, if it arrives while busy is 1 or while `init_done` is 0.
- R10: Read data appears on `hrdata` during the data phase, the cycle after the address phase. At all other times `hrdata` is 0. Reads of 0x08, of unmapped offsets and of accesses with `haddr[1:0]` not 0 return 0, and such unaligned accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 5 | Byte offset within the block |
| htrans | input | 2 | Transfer type; NONSEQ or SEQ start an access |
| hwrite | input | 1 | 1 for write, 0 for read |
| hready | input | 1 | Bus ready from the interconnect |
| hwdata | input | 64 | Write data, valid in the data phase |
| hrdata | output | 64 | Read data, valid in the data phase |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Slave response, always OKAY |
| init_done | input | 1 | Card initialization finished |
| clk_div | output | 8 | Card clock divider value |
| blk_req | output | 1 | One-cycle block read request |
| blk_addr | output | 64 | Block address accompanying the request |
| blk_valid | input | 1 | Backend word strobe |
| blk_data | input | 64 | Backend word |

## Verification
The bench sends command writes during busy, before initialization and with the wrong value. A design that gated these badly would raise a stray request or busy would come back, and the status polling would see it. Backend strobes are driven while idle and in the request cycle itself. A design that took them in would shift every later mailbox word by one. The mailbox is drained past its end, and a block is read only partly before a new command. A pointer that wrapped or was not rewound would return word 0 or a stale word where word 63 or word 0 is expected. Word streams with gaps check that busy clears only after the 64th strobe.

// File: rtl/sd_blockread_regs.sv
module sd_blockread_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64,
  parameter int DIV_W  = 8,
  parameter int WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp,
  input  logic              init_done,
  output logic [DIV_W-1:0]  clk_div,
  output logic              blk_req,
  output logic [DATA_W-1:0] blk_addr,
  input  logic              blk_valid,
  input  logic [DATA_W-1:0] blk_data
);
  localparam int PTR_W = $clog2(WORDS);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] OFF_DIV  = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_ADDR = OFF_W'(4);
  localparam logic [OFF_W-1:0] OFF_MBOX = OFF_W'(6);
  localparam logic [PTR_W-1:0] LAST     = PTR_W'(WORDS - 1);

  typedef enum logic [1:0] {S_READY, S_REQ, S_FILL} state_t;

  state_t            st, st_n;
  logic              dp_act, dp_wr, busy, wr_en, rd_en, cmd_go;
  logic [OFF_W-1:0]  dp_off;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] addr_q;
  logic [PTR_W-1:0]  fill_q, ptr_q;
  logic [DATA_W-1:0] mem [WORDS];

  assign busy   = (st != S_READY);
  assign wr_en  = dp_act & dp_wr;
  assign rd_en  = dp_act & ~dp_wr;
  assign cmd_go = wr_en && dp_off == OFF_CMD && hwdata == DATA_W'(4) && init_done && !busy;

  assign hresp    = 1'b0;
  assign clk_div  = div_q;
  assign blk_req  = (st == S_REQ);
  assign blk_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_act <= 1'b0;
      dp_wr  <= 1'b0;
      dp_off <= '0;
    end else begin
      dp_act <= hsel && hready && (htrans inside {2'b10, 2'b11}) && haddr[1:0] == 2'b00;
      dp_wr  <= hwrite;
      dp_off <= haddr[ADDR_W-1:2];
    end
  end

  always_comb begin
    st_n      = st;
    hreadyout = 1'b1;
    case (st)
      S_READY: if (cmd_go) st_n = S_REQ;
      S_REQ:   st_n = S_FILL;
      S_FILL:  if (blk_valid && fill_q == LAST) st_n = S_READY;
      default: st_n = S_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_READY;
      div_q  <= '0;
      addr_q <= '0;
      fill_q <= '0;
      ptr_q  <= '0;
    end else begin
      st <= st_n;
      if (wr_en && dp_off == OFF_DIV)  div_q  <= hwdata[DIV_W-1:0];
      if (wr_en && dp_off == OFF_ADDR) addr_q <= hwdata;
      if (st == S_REQ) fill_q <= '0;
      else if (st == S_FILL && blk_valid) fill_q <= fill_q + 1'b1;
      if (cmd_go) ptr_q <= '0;
      else if (rd_en && dp_off == OFF_MBOX && ptr_q != LAST) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && blk_valid) mem[fill_q] <= blk_data;
  end

  always_comb begin
    hrdata = '0;
    if (rd_en) begin
      case (dp_off)
        OFF_DIV:  hrdata = DATA_W'(div_q);
        OFF_STAT: hrdata = DATA_W'({busy, init_done});
        OFF_ADDR: hrdata = addr_q;
        OFF_MBOX: hrdata = mem[ptr_q];
        default:  hrdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sd_blockread_regs_chk.sv
module sd_blockread_regs_chk #(
  parameter int WORDS = 64
) (
  input logic clk,
  input logic rst_n,
  input logic init_done,
  input logic busy,
  input logic blk_req,
  input logic blk_valid,
  input logic hreadyout,
  input logic hresp
);
  localparam int CNT_W = $clog2(WORDS) + 1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (blk_req) cnt <= '0;
    else if (busy && blk_valid) cnt <= cnt + 1'b1;
  end

  assert_zero_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hreadyout && !hresp);

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |=> !blk_req);

  assert_req_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> blk_req);

  assert_no_start_uninit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> !$rose(busy));

  assert_no_req_in_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_req) |=> !blk_req);

  assert_fill_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_req && blk_valid && cnt == CNT_W'(WORDS - 1)) |=> !busy);

  assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_req && !(blk_valid && cnt == CNT_W'(WORDS - 1))) |=> busy);
endmodule

bind sd_blockread_regs sd_blockread_regs_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .busy(busy),
  .blk_req(blk_req), .blk_valid(blk_valid), .hreadyout(hreadyout), .hresp(hresp));

// File: tb/sim_sd_blockread_regs.sv
module sim_sd_blockread_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0, hready = 1'b1;
  logic [4:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic [63:0] hwdata = '0, hrdata, blk_addr, blk_data = '0;
  logic        hreadyout, hresp, init_done = 1'b0, blk_req, blk_valid = 1'b0;
  logic [7:0]  clk_div;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  sd_blockread_regs u0 (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp), .init_done(init_done), .clk_div(clk_div),
    .blk_req(blk_req), .blk_addr(blk_addr), .blk_valid(blk_valid), .blk_data(blk_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int          m_st = 0, m_fill = 0, m_ptr = 0, m_off = 0;
  bit          m_dp = 0, m_dpw = 0;
  logic [7:0]  m_div = '0;
  logic [63:0] m_addr = '0;
  logic [63:0] m_buf [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_fill = 0; m_ptr = 0; m_dp = 0; m_div = '0; m_addr = '0;
    end else begin
      bit go;
      go = 0;
      if (m_dp && m_dpw) begin
        if (m_off == 'h00) m_div = hwdata[7:0];
        if (m_off == 'h10) m_addr = hwdata;
        if (m_off == 'h08 && hwdata == 64'd4 && init_done && m_st == 0) go = 1;
      end
      if (m_dp && !m_dpw && m_off == 'h18 && m_ptr < 63) m_ptr++;
      if (m_st == 1) begin m_st = 2; m_fill = 0; end
      else if (m_st == 2) begin
        if (blk_valid) begin
          m_buf[m_fill] = blk_data;
          m_fill++;
          if (m_fill == 64) m_st = 0;
        end
      end else if (go) begin m_st = 1; m_ptr = 0; end
      m_dp  = hsel && hready && htrans[1] && haddr[1:0] == 2'b00;
      m_dpw = hwrite;
      m_off = int'(haddr);
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] e;
      string tg;
      e = '0; tg = "R10";
      if (m_dp && !m_dpw) begin
        case (m_off)
          'h00: begin e = 64'(m_div); tg = "R2"; end
          'h04: begin e = 64'({m_st != 0, init_done}); tg = "R3"; end
          'h10: begin e = m_addr; tg = "R5"; end
          'h18: begin e = m_buf[m_ptr]; tg = "R8"; end
          default: e = '0;
        endcase
      end
      chk(hrdata, e, tg);
      chk(64'(clk_div), 64'(m_div), "R2");
      chk(64'({hreadyout, hresp}), 64'b10, "R4");
      chk(64'(blk_req), 64'(m_st == 1), "R6");
      if (blk_req) chk(blk_addr, m_addr, "R5");
    end
  end

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk); hsel = 1; htrans = 2'b10; hwrite = 1; haddr = a;
    @(negedge clk); hsel = 0; htrans = 2'b00; hwdata = d;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); hsel = 1; htrans = 2'b10; hwrite = 0; haddr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hsel = 0; htrans = 2'b00;
    end
  endtask

  task automatic stream(input logic [31:0] seed, input bit gaps, input bit early);
    do @(negedge clk); while (!blk_req);
    if (early) begin blk_valid = 1; blk_data = 64'hDEAD_BEEF_0BAD_F00D; end
    for (int i = 0; i < 64; i++) begin
      if (gaps && i % 5 == 2) begin
        @(negedge clk); blk_valid = 0;
      end
      @(negedge clk); blk_valid = 1; blk_data = {seed, 32'(i)};
    end
    @(negedge clk); blk_valid = 0;
  endtask

  task automatic run_block(input logic [63:0] a, input logic [31:0] seed, input bit gaps,
                           input bit early);
    wr(5'h10, a);
    fork
      begin
        wr(5'h08, 64'd4);
        wr(5'h08, 64'd4); // R9: ignored while busy
        for (int i = 0; i < 110; i++) rd(5'h04); // R3, R7 busy polling
        idle(1);
      end
      stream(seed, gaps, early);
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values
    chk(64'(clk_div), 64'd0, "R1");
    chk(64'(blk_req), 64'd0, "R1");
    chk(64'({hreadyout, hresp}), 64'b10, "R1");
    rd(5'h10); rd(5'h04); idle(2);
    // R2: divider writes, including truncation
    wr(5'h00, 64'd1); rd(5'h00); idle(1);
    wr(5'h00, 64'h1FC); rd(5'h00); idle(1);
    // R3: status write has no effect; R10: cmd and unmapped read as 0, unaligned ignored
    wr(5'h04, 64'hFFFF); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h1C); idle(1);
    wr(5'h01, 64'h55); rd(5'h00); rd(5'h02); idle(1);
    // R5: address register
    wr(5'h10, 64'h0123_4567_89AB_CDEF); rd(5'h10); idle(1);
    // R9: command before init is ignored
    wr(5'h08, 64'd4); rd(5'h04); idle(4);
    init_done = 1;
    // R6: wrong command value starts nothing
    wr(5'h08, 64'd5); rd(5'h04); idle(4);
    // R7: strobes while idle are ignored
    @(negedge clk); blk_valid = 1; blk_data = 64'hBAD0; @(negedge clk); blk_valid = 0;
    // first block with gaps; R8 drain past end
    run_block(64'h2000_0000, 32'hA5A5_0001, 1, 0);
    for (int i = 0; i < 67; i++) rd(5'h18);
    idle(2);
    // second block, back-to-back words, strobe during request cycle
    run_block(64'h2000_0200, 32'h5A5A_0002, 0, 1);
    for (int i = 0; i < 10; i++) rd(5'h18);
    idle(1);
    // R8: a new command rewinds the pointer
    run_block(64'h2000_0400, 32'h3C3C_0003, 1, 0);
    for (int i = 0; i < 65; i++) rd(5'h18);
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule